// File: doc/BRIEF.md
# Signaling Change Event Queue with Interrupts

This block stores change-of-signaling events in a first-in first-out queue until the host reads them. Each event carries a channel index and the new signaling bits. The host drains the queue one word at a time. The block reports its fill state through three sticky interrupt bits, a live status bit and a single combined interrupt line.

The first interrupt flags occupancy above a programmable threshold. The second flags a hold-off timer expiring while events are waiting. The third flags an event lost to a full queue. Each interrupt bit has its own mask. The host clears the bits either by reading them (clear-on-read mode) or by writing ones to them (write-one-to-clear mode).

Top module: `sig_chg_fifo`

## Requirements
- R1: `level` reports the number of stored entries, from 0 to `DEPTH` (64). On a cycle with an accepted write and an accepted read, the count does not change.
- R2: Entries leave in the order they were written. `rd_data` shows the oldest entry laid out as bits [4:0] channel, bits [8:5] signaling and bits [15:9] zero. `rd_data` is zero when the queue is empty, and a read strobe on an empty queue changes nothing.
- R3: A write to a full queue with no read in the same cycle is dropped, and the stored entries stay as they were. A write together with a read on a full queue is accepted.
- R4: `thr_status` is 1 exactly while `level` is greater than `thresh`. It does not latch.
- R5: `irq_bits[0]` (threshold) becomes 1 on the clock edge after a cycle in which `level` > `thresh`.
- R6: The hold-off timer loads `tmr_reload` while the queue is empty. While the queue is non-empty it counts down once per cycle. On a non-empty cycle with the count at zero, it reloads and sets `irq_bits[1]` (timer) at that edge. So after a write into an empty queue, `irq_bits[1]` rises `tmr_reload`+1 edges later if the queue stays non-empty.
- R7: `irq_bits[2]` (overflow) becomes 1 on the edge that drops a write, as described in R3. A write together with a read on a full queue does not set it.
- R8: In clear-on-read mode (`cor_mode`=1), `stat_rd` clears all three bits and `clr_we` has no effect. Otherwise `clr_we` clears the bits that are 1 in `clr_val`, and `stat_rd` has no effect. A set condition in the same cycle wins over a clear.
- R9: `irq_out` is 1 when some interrupt bit is 1 and its `irq_mask` bit is 0 (mask bit 1 = masked).
- R10: After synchronous reset, the queue is empty and all interrupt bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Event write strobe |
| wr_chan | input | 5 | Channel index of the event |
| wr_sig | input | 4 | New signaling bits |
| rd_en | input | 1 | Host pop strobe |
| rd_data | output | 16 | Oldest entry, or zero when empty |
| level | output | 7 | Number of stored entries |
| thresh | input | 7 | Occupancy threshold |
| tmr_reload | input | 16 | Hold-off timer reload value |
| irq_mask | input | 3 | Per-bit interrupt mask, 1 = masked |
| cor_mode | input | 1 | 1 = clear-on-read, 0 = write-one-to-clear |
| stat_rd | input | 1 | Host read of the interrupt bits |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_val | input | 3 | Bits to clear on `clr_we` |
| thr_status | output | 1 | Live occupancy-above-threshold status |
| irq_bits | output | 3 | Sticky interrupts: [0] threshold, [1] timer, [2] overflow |
| irq_out | output | 1 | Combined unmasked interrupt |

## Verification
The bench fills the queue to capacity and pushes one more write with no read. A design that let the write through would corrupt the oldest entry or miscount, and the drained order would not match. It then writes and reads together at full, which a wrong design would flag as an overflow or refuse. It clears interrupt bits while their conditions still hold, so a design that lets the clear win would drop the bit. It also runs the timer with a reload of zero and across drain-to-empty, which catches an off-by-one expiry or a count that carries over from one busy period to the next.

// File: rtl/sig_chg_pkg.sv
package sig_chg_pkg;

    localparam int CHAN_W = 5;
    localparam int SIG_W  = 4;
    localparam int WORD_W = 16;
    localparam int RSVD_W = WORD_W - CHAN_W - SIG_W;
    localparam int N_IRQ  = 3;

    typedef struct packed {
        logic [RSVD_W-1:0] rsvd;
        logic [SIG_W-1:0]  sig;
        logic [CHAN_W-1:0] chan;
    } sig_evt_t;

    typedef enum int {
        IRQ_THR = 0,
        IRQ_TMR = 1,
        IRQ_OVF = 2
    } irq_idx_e;

    function automatic sig_evt_t make_evt(logic [CHAN_W-1:0] c, logic [SIG_W-1:0] s);
        sig_evt_t e;
        e.rsvd = '0;
        e.sig  = s;
        e.chan = c;
        return e;
    endfunction

endpackage

// File: rtl/sig_chg_store.sv
module sig_chg_store
    import sig_chg_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push_req,
    input  logic                         pop_req,
    input  sig_evt_t                     wdata,
    output sig_evt_t                     rdata,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         push_drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH+1);

    sig_evt_t        mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic            full, empty, do_pop, do_push;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_pop  = pop_req && !empty;
    assign do_push = push_req && (!full || do_pop);
    assign push_drop = push_req && full && !pop_req;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

    assign rdata = empty ? sig_evt_t'('0) : mem[rp];

endmodule

// File: rtl/sig_chg_timer.sv
module sig_chg_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [TMR_W-1:0] reload,
    output logic             expire
);
    logic [TMR_W-1:0] cnt;

    assign expire = active && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (!active || expire) cnt <= reload;
        else                        cnt <= cnt - 1'b1;
    end

endmodule

// File: rtl/sig_chg_irq.sv
module sig_chg_irq
    import sig_chg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] set_vec,
    input  logic             cor_mode,
    input  logic             stat_rd,
    input  logic             clr_we,
    input  logic [N_IRQ-1:0] clr_val,
    input  logic [N_IRQ-1:0] mask,
    output logic [N_IRQ-1:0] bits,
    output logic             any
);
    logic [N_IRQ-1:0] clr_vec;

    always_comb begin
        if (cor_mode) clr_vec = stat_rd ? '1 : '0;
        else          clr_vec = clr_we ? clr_val : '0;
    end

    for (genvar i = 0; i < N_IRQ; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) bits[i] <= 1'b0;
            else     bits[i] <= set_vec[i] | (bits[i] & ~clr_vec[i]);
        end
    end

    assign any = |(bits & ~mask);

endmodule

// File: rtl/sig_chg_fifo.sv
module sig_chg_fifo
    import sig_chg_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int TMR_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [4:0]                  wr_chan,
    input  logic [3:0]                  wr_sig,
    input  logic                        rd_en,
    output logic [15:0]                 rd_data,
    output logic [$clog2(DEPTH+1)-1:0]  level,
    input  logic [$clog2(DEPTH+1)-1:0]  thresh,
    input  logic [TMR_W-1:0]            tmr_reload,
    input  logic [2:0]                  irq_mask,
    input  logic                        cor_mode,
    input  logic                        stat_rd,
    input  logic                        clr_we,
    input  logic [2:0]                  clr_val,
    output logic                        thr_status,
    output logic [2:0]                  irq_bits,
    output logic                        irq_out
);
    sig_evt_t         head;
    logic             drop, tmr_fire;
    logic [N_IRQ-1:0] set_vec;

    sig_chg_store #(.DEPTH(DEPTH)) store_i (
        .clk       (clk),
        .rst       (rst),
        .push_req  (wr_en),
        .pop_req   (rd_en),
        .wdata     (make_evt(wr_chan, wr_sig)),
        .rdata     (head),
        .level     (level),
        .push_drop (drop)
    );

    sig_chg_timer #(.TMR_W(TMR_W)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .active (level != '0),
        .reload (tmr_reload),
        .expire (tmr_fire)
    );

    assign thr_status = (level > thresh);

    always_comb begin
        set_vec          = '0;
        set_vec[IRQ_THR] = thr_status;
        set_vec[IRQ_TMR] = tmr_fire;
        set_vec[IRQ_OVF] = drop;
    end

    sig_chg_irq irq_i (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .cor_mode (cor_mode),
        .stat_rd  (stat_rd),
        .clr_we   (clr_we),
        .clr_val  (clr_val),
        .mask     (irq_mask),
        .bits     (irq_bits),
        .any      (irq_out)
    );

    assign rd_data = head;

endmodule

// File: rtl/sig_chg_fifo_chk.sv
module sig_chg_fifo_chk #(
    parameter int DEPTH = 64,
    parameter int TMR_W = 16
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        wr_en,
    input logic                        rd_en,
    input logic [15:0]                 rd_data,
    input logic [$clog2(DEPTH+1)-1:0]  level,
    input logic [$clog2(DEPTH+1)-1:0]  thresh,
    input logic [2:0]                  irq_mask,
    input logic                        cor_mode,
    input logic                        stat_rd,
    input logic [2:0]                  irq_bits,
    input logic                        irq_out
);
    localparam int LW = $clog2(DEPTH+1);

    a_r1_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

    a_r2_empty_zero: assert property (@(posedge clk) disable iff (rst)
        (level == '0) |-> (rd_data == '0));

    a_r3_full_drop_keeps: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && level == LW'(DEPTH)) |=> (level == LW'(DEPTH)));

    a_r5_thr_sets: assert property (@(posedge clk) disable iff (rst)
        (level > thresh) |=> irq_bits[0]);

    a_r6_no_timer_when_empty: assert property (@(posedge clk) disable iff (rst)
        (level == '0 && cor_mode && stat_rd) |=> !irq_bits[1]);

    a_r7_overflow_sets: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && level == LW'(DEPTH)) |=> irq_bits[2]);

    a_r9_all_masked: assert property (@(posedge clk) disable iff (rst)
        (&irq_mask) |-> !irq_out);

endmodule

bind sig_chg_fifo sig_chg_fifo_chk #(.DEPTH(DEPTH), .TMR_W(TMR_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .level    (level),
    .thresh   (thresh),
    .irq_mask (irq_mask),
    .cor_mode (cor_mode),
    .stat_rd  (stat_rd),
    .irq_bits (irq_bits),
    .irq_out  (irq_out)
);

// File: tb/sig_chg_fifo_tb_top.sv
module sig_chg_fifo_tb_top;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 0, rd_en = 0, cor_mode = 0, stat_rd = 0, clr_we = 0;
    logic [4:0]  wr_chan = 0;
    logic [3:0]  wr_sig = 0;
    logic [6:0]  thresh = 7'd4;
    logic [15:0] tmr_reload = 16'd10;
    logic [2:0]  irq_mask = 0, clr_val = 0;
    logic [15:0] rd_data;
    logic [6:0]  level;
    logic        thr_status, irq_out;
    logic [2:0]  irq_bits;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    sig_chg_fifo dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chan(wr_chan), .wr_sig(wr_sig),
        .rd_en(rd_en), .rd_data(rd_data), .level(level), .thresh(thresh),
        .tmr_reload(tmr_reload), .irq_mask(irq_mask), .cor_mode(cor_mode),
        .stat_rd(stat_rd), .clr_we(clr_we), .clr_val(clr_val),
        .thr_status(thr_status), .irq_bits(irq_bits), .irq_out(irq_out)
    );

    // behavioural reference
    logic [15:0] q[$];
    int          m_tmr;
    logic [2:0]  m_irq;

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_tmr = 0;
            m_irq = 3'b000;
        end else begin
            int         sz;
            logic [2:0] setv, clrv;
            bit         pop, push;
            sz = q.size();
            setv[0] = (sz > int'(thresh));
            setv[1] = (sz != 0) && (m_tmr == 0);
            setv[2] = wr_en && !rd_en && (sz == DEPTH);
            clrv = cor_mode ? (stat_rd ? 3'b111 : 3'b000) : (clr_we ? clr_val : 3'b000);
            m_irq = (m_irq & ~clrv) | setv;
            if (sz == 0 || m_tmr == 0) m_tmr = int'(tmr_reload);
            else                       m_tmr = m_tmr - 1;
            pop  = rd_en && sz > 0;
            push = wr_en && (sz < DEPTH || pop);
            if (pop)  void'(q.pop_front());
            if (push) q.push_back({7'b0, wr_sig, wr_chan});
        end
    end

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        int sz;
        sz = q.size();
        chk("R1 R3 R10 level", int'(level), sz);
        chk("R2 R3 rd_data", int'(rd_data), sz > 0 ? int'(q[0]) : 0);
        chk("R4 thr_status", int'(thr_status), int'(sz > int'(thresh)));
        chk("R5 R8 R10 irq threshold", int'(irq_bits[0]), int'(m_irq[0]));
        chk("R6 R8 irq timer", int'(irq_bits[1]), int'(m_irq[1]));
        chk("R7 R8 irq overflow", int'(irq_bits[2]), int'(m_irq[2]));
        chk("R9 irq_out", int'(irq_out), int'(|(m_irq & ~irq_mask)));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic put(int c, int s);
        wr_en = 1; wr_chan = 5'(c); wr_sig = 4'(s);
        tick();
        wr_en = 0;
    endtask

    task automatic take(int n);
        rd_en = 1;
        for (int i = 0; i < n; i++) tick();
        rd_en = 0;
    endtask

    task automatic w1c(logic [2:0] v);
        clr_we = 1; clr_val = v;
        tick();
        clr_we = 0; clr_val = 0;
    endtask

    task automatic cor_read();
        stat_rd = 1;
        tick();
        stat_rd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R10 reset state
        idle(2);
        @(negedge clk); rst = 0;
        tick();

        // R2 order and layout, read on empty ignored
        put(3, 9); put(17, 5); put(31, 15);
        take(3);
        take(2);
        w1c(3'b111);

        // R4 R5 R6 threshold and timer, clear while condition holds (R8)
        for (int i = 0; i < 6; i++) put(i, i + 1);
        idle(14);
        w1c(3'b001);
        w1c(3'b010);
        take(6);
        idle(3);
        w1c(3'b111);
        idle(2);

        // R6 reload zero, one entry, then drain restart
        tmr_reload = 16'd0;
        put(7, 2);
        idle(3);
        take(1);
        w1c(3'b111);
        tmr_reload = 16'd5;
        put(8, 3);
        idle(8);
        take(1);
        w1c(3'b111);

        // R3 R7 fill, overflow drop, read+write at full
        thresh = 7'd63;
        for (int i = 0; i < DEPTH; i++) put(i % 32, i % 16);
        put(30, 14);
        put(29, 13);
        wr_en = 1; rd_en = 1; wr_chan = 5'd21; wr_sig = 4'd6;
        tick();
        wr_en = 0; rd_en = 0;
        w1c(3'b100);
        idle(2);

        // R8 clear-on-read mode, R9 masking
        cor_mode = 1;
        w1c(3'b111);
        irq_mask = 3'b111;
        idle(2);
        irq_mask = 3'b011;
        idle(1);
        irq_mask = 3'b100;
        idle(1);
        take(DEPTH);
        idle(2);
        cor_read();
        irq_mask = 3'b000;
        idle(3);
        cor_read();
        idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule